// File: doc/BRIEF.md
# ECC Error Capture and Status Registers

This block sits beside a DRAM controller's ECC datapath. It records the error events that the datapath reports and shows them to software through five registers. The datapath pulses a correctable or an uncorrectable indication. Each pulse comes with the 33-bit physical address of the failing access, the channel that carried it and the 8-bit ECC syndrome. Three other one-cycle indications report a refresh timeout, a locked access aimed at non-memory space, and a thermal sensor trip.

Each event sets a sticky status bit, and software clears that bit by writing 1 to it. Only one error's location is kept. An uncorrectable error may displace a logged correctable one, but nothing else overwrites a capture that is already held. A command register selects which status bits drive the system error line. That line is a level, and it stays high until software clears every enabled status bit that is set.

Software reaches the registers over a simple valid/ready port that uses byte offsets. The port accepts a request every cycle. A read returns its data one cycle after the request is accepted.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, all five registers read zero and `sys_err` is low.
- R2: Status bit positions are: bit 0 correctable ECC error, bit 1 uncorrectable ECC error, bit 8 refresh timeout, bit 9 locked access to non-memory space, bit 11 thermal event. An event pulse sets its bit at the next clock edge. All other status bits always read zero.
- R3: A write to the status register clears each bit in mask 0x0B03 where the write data holds 1, and leaves unchanged each bit where the data holds 0. An event that arrives in the same cycle as a clear of its bit leaves that bit set.
- R4: The command register uses the same bit positions as the status register. Only the bits in mask 0x0B03 are stored, and the other bits read zero.
- R5: The address pointer register reads the captured address bits 31:7 in bits 31:7 and the captured channel in bit 0. Bits 6:1 read zero. The extended address register reads captured address bit 32 in bit 0, and its other bits read zero. The syndrome register reads the captured 8-bit syndrome.
- R6: When neither ECC status bit is set, the first ECC error loads the address, channel and syndrome at the same edge that sets its status bit. If a correctable and an uncorrectable error arrive together, the uncorrectable error's information is captured.
- R7: An uncorrectable error that arrives while the uncorrectable bit is clear replaces the capture, even when a correctable error is logged. Both status bits are then set.
- R8: A correctable error that arrives while either ECC status bit is set leaves the capture unchanged. An uncorrectable error that arrives while the uncorrectable bit is set also leaves it unchanged.
- R9: `sys_err` is high exactly when some status bit and its command bit are both set. It follows the registers in the same cycle, so it rises the cycle after an enabled event and falls the cycle after the last contributing bit is cleared.
- R10: `req_ready` is always high. A read accepted in cycle N returns `rsp_valid` high and the register value as it stood in cycle N, one cycle later. The register offsets are 0x00 status, 0x04 command, 0x08 address pointer, 0x0C extended address and 0x10 syndrome. Other offsets read zero. Writes to the capture registers or to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| fail_addr | input | 33 | Physical address of the failing access |
| fail_chan | input | 1 | Channel of the failing access |
| fail_syn | input | 8 | ECC syndrome of the failing access |
| rfto_evt | input | 1 | Refresh timeout pulse |
| lock_evt | input | 1 | Locked access to non-memory space pulse |
| therm_evt | input | 1 | Thermal sensor event pulse |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 5 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| sys_err | output | 1 | System error level |

## Verification
The assertions assume that the address, channel and syndrome inputs are meaningful only in a cycle where an ECC pulse is high. The capture checks therefore compare against those inputs only in such cycles. They also assume that a register request is never held across reset. The stimulus drives each event as a single-cycle pulse and issues every request for exactly one cycle. It deliberately lines up correctable and uncorrectable pulses in the same cycle, and event pulses with status clears, so that the ordering rules come into play.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W = 33,
  parameter int SYN_W  = 8,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic              fail_chan,
  input  logic [SYN_W-1:0]  fail_syn,
  input  logic              rfto_evt,
  input  logic              lock_evt,
  input  logic              therm_evt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              sys_err
);
  localparam logic [15:0]      EMASK    = 16'h0B03;
  localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(5'h00);
  localparam logic [OFF_W-1:0] OFF_CMD  = OFF_W'(5'h04);
  localparam logic [OFF_W-1:0] OFF_PTR  = OFF_W'(5'h08);
  localparam logic [OFF_W-1:0] OFF_EXT  = OFF_W'(5'h0C);
  localparam logic [OFF_W-1:0] OFF_SYN  = OFF_W'(5'h10);

  logic [15:0]       stat_q, cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              chan_q;
  logic [SYN_W-1:0]  syn_q;
  logic [31:0]       rd_mux;

  assign req_ready = 1'b1;

  wire acc    = req_valid & req_ready;
  wire wr_acc = acc & req_write;
  wire rd_acc = acc & ~req_write;

  wire [15:0] evt = {4'b0, therm_evt, 1'b0, lock_evt, rfto_evt, 6'b0, ue_evt, ce_evt};
  wire [15:0] clr = (wr_acc && req_offset == OFF_STAT) ? (req_wdata[15:0] & EMASK) : 16'h0;

  wire ue_cap = ue_evt & ~stat_q[1];
  wire ce_cap = ce_evt & ~ue_evt & ~stat_q[1] & ~stat_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      if (wr_acc && req_offset == OFF_CMD)
        cmd_q <= req_wdata[15:0] & EMASK;
      if (ue_cap || ce_cap) begin
        addr_q <= fail_addr;
        chan_q <= fail_chan;
        syn_q  <= fail_syn;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_offset)
      OFF_STAT: rd_mux[15:0] = stat_q;
      OFF_CMD:  rd_mux[15:0] = cmd_q;
      OFF_PTR:  rd_mux = {addr_q[31:7], 6'b0, chan_q};
      OFF_EXT:  rd_mux[0] = addr_q[32];
      OFF_SYN:  rd_mux[SYN_W-1:0] = syn_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_mux;
    end
  end

  assign sys_err = |(stat_q & cmd_q);
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_evt,
  input logic        ue_evt,
  input logic [7:0]  fail_syn,
  input logic        fail_chan,
  input logic [15:0] stat,
  input logic [15:0] cmd,
  input logic [7:0]  syn,
  input logic        chan,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        sys_err
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~16'h0B03) == 16'h0);

  a_r4_cmd_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd & ~16'h0B03) == 16'h0);

  a_r2_ce_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> stat[0]);

  a_r6_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && stat[1:0] == 2'b00) |=> (syn == $past(fail_syn) && chan == $past(fail_chan)));

  a_r7_ue_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !stat[1]) |=> (syn == $past(fail_syn) && stat[1]));

  a_r8_ce_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && stat[1:0] != 2'b00) |=> $stable(syn));

  a_r8_ue_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && stat[1]) |=> $stable(syn));

  a_r9_err_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> (stat != 16'h0 && cmd != 16'h0));

  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
  .fail_syn(fail_syn), .fail_chan(fail_chan), .stat(stat_q), .cmd(cmd_q),
  .syn(syn_q), .chan(chan_q), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .sys_err(sys_err)
);

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/1ps
module sim_ecc_err_log;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_evt = 0, ue_evt = 0, fail_chan = 0, rfto_evt = 0, lock_evt = 0, therm_evt = 0;
  logic [32:0] fail_addr = '0;
  logic [7:0]  fail_syn = '0;
  logic req_valid = 0, req_write = 0;
  logic [4:0]  req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, sys_err;
  logic [31:0] rsp_rdata;
  int checks = 0, failures = 0;

  logic [15:0] m_stat = '0, m_cmd = '0;
  logic [32:0] m_addr = '0;
  logic        m_chan = 0;
  logic [7:0]  m_syn = '0;

  always #2.5 clk = ~clk;

  ecc_err_log u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] off);
    case (off)
      5'h00: return {16'h0, m_stat};
      5'h04: return {16'h0, m_cmd};
      5'h08: return {m_addr[31:7], 6'b0, m_chan};
      5'h0C: return {31'b0, m_addr[32]};
      5'h10: return {24'h0, m_syn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic tick(input string tag);
    logic rd;
    logic [31:0] exp_rd;
    logic [15:0] clr, ev;
    rd = req_valid && !req_write;
    exp_rd = m_read(req_offset);
    if (ue_evt && !m_stat[1]) begin
      m_addr = fail_addr; m_chan = fail_chan; m_syn = fail_syn;
    end else if (ce_evt && !ue_evt && m_stat[1:0] == 2'b00) begin
      m_addr = fail_addr; m_chan = fail_chan; m_syn = fail_syn;
    end
    clr = 16'h0;
    if (req_valid && req_write && req_offset == 5'h00) clr = req_wdata[15:0] & 16'h0B03;
    ev = 16'h0;
    if (ce_evt) ev[0] = 1;
    if (ue_evt) ev[1] = 1;
    if (rfto_evt) ev[8] = 1;
    if (lock_evt) ev[9] = 1;
    if (therm_evt) ev[11] = 1;
    m_stat = (m_stat & ~clr) | ev;
    if (req_valid && req_write && req_offset == 5'h04) m_cmd = req_wdata[15:0] & 16'h0B03;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R10 rsp_valid"}, {31'b0, rsp_valid}, {31'b0, rd});
    if (rd) check({tag, " read"}, rsp_rdata, exp_rd);
    check({tag, " R9 sys_err"}, {31'b0, sys_err}, {31'b0, |(m_stat & m_cmd)});
    check({tag, " R10 ready"}, {31'b0, req_ready}, 32'h1);
  endtask

  task automatic rd(input logic [4:0] off, input string tag);
    req_valid = 1; req_write = 0; req_offset = off;
    tick(tag);
    req_valid = 0;
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] d, input string tag);
    req_valid = 1; req_write = 1; req_offset = off; req_wdata = d;
    tick(tag);
    req_valid = 0; req_write = 0;
  endtask

  task automatic ecc(input logic ce, input logic ue, input logic [32:0] a,
                     input logic ch, input logic [7:0] s, input string tag);
    ce_evt = ce; ue_evt = ue; fail_addr = a; fail_chan = ch; fail_syn = s;
    tick(tag);
    ce_evt = 0; ue_evt = 0; fail_addr = '0; fail_chan = 0; fail_syn = '0;
  endtask

  task automatic rd_all(input string tag);
    rd(5'h00, {tag, " status"});
    rd(5'h08, {tag, " R5 ptr"});
    rd(5'h0C, {tag, " R5 ext"});
    rd(5'h10, {tag, " R5 syn"});
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 sys_err after reset", {31'b0, sys_err}, 32'h0);
    rd_all("R1 reset");
    rd(5'h04, "R1 reset cmd");

    // R6 first correctable error captures
    ecc(1, 0, 33'h1_2345_67FF, 1, 8'hA5, "R6 ce first");
    rd_all("R6 after ce");
    // R8 second correctable keeps capture
    ecc(1, 0, 33'h0_0000_0100, 0, 8'h11, "R8 ce again");
    rd_all("R8 after ce");
    // R7 uncorrectable replaces correctable
    ecc(0, 1, 33'h0_FFFF_FF80, 0, 8'h3C, "R7 ue over ce");
    rd_all("R7 after ue");
    // R8 second uncorrectable keeps
    ecc(0, 1, 33'h1_0000_0000, 1, 8'hEE, "R8 ue again");
    rd_all("R8 after ue2");
    // R3 partial clear and zero write
    wr(5'h00, 32'h0000_0000, "R3 write zero");
    rd(5'h00, "R3 zero no effect");
    wr(5'h00, 32'hFFFF_F4FE, "R3 clear ue only");
    rd(5'h00, "R3 after clear ue");
    // R8 ce while ce logged, ue clear
    ecc(1, 0, 33'h0_1111_1111, 1, 8'h77, "R8 ce with ce set");
    rd_all("R8 ce with ce set");
    wr(5'h00, 32'h0000_0B03, "R3 clear all");
    rd(5'h00, "R3 cleared");
    // R6 simultaneous ce and ue
    ecc(1, 1, 33'h1_8000_0080, 1, 8'h5A, "R6 ce+ue");
    rd_all("R6 ce+ue");
    // R3 event collides with clear
    req_valid = 1; req_write = 1; req_offset = 5'h00; req_wdata = 32'h0000_0003;
    ue_evt = 1; fail_addr = 33'h0_0000_0F00; fail_syn = 8'h99;
    tick("R3 set beats clear");
    req_valid = 0; req_write = 0; ue_evt = 0;
    rd_all("R3 after collision");
    wr(5'h00, 32'h0000_0B03, "R3 clear all 2");
    // R2 other sources
    rfto_evt = 1; tick("R2 refresh"); rfto_evt = 0;
    lock_evt = 1; tick("R2 lock"); lock_evt = 0;
    therm_evt = 1; tick("R2 thermal"); therm_evt = 0;
    rd(5'h00, "R2 other bits");
    // R4 command register
    wr(5'h04, 32'hFFFF_FFFF, "R4 cmd all");
    rd(5'h04, "R4 cmd readback");
    wr(5'h04, 32'h0000_0200, "R9 enable lock only");
    wr(5'h00, 32'h0000_0900, "R9 clear non-lock");
    wr(5'h00, 32'h0000_0200, "R9 clear lock drops");
    wr(5'h04, 32'h0000_0001, "R9 enable ce");
    ecc(1, 0, 33'h0_0ABC_DE00, 0, 8'h42, "R9 ce raises");
    tick("R9 level held");
    wr(5'h00, 32'h0000_0001, "R9 clear ce");
    // R10 unmapped and read-only writes
    wr(5'h08, 32'hFFFF_FFFF, "R10 ptr write ignored");
    wr(5'h10, 32'hFFFF_FFFF, "R10 syn write ignored");
    wr(5'h14, 32'hFFFF_FFFF, "R10 unmapped write");
    rd_all("R10 after ignored writes");
    rd(5'h14, "R10 unmapped read");
    rd(5'h1C, "R10 unmapped read hi");
    rd(5'h04, "R10 cmd intact");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule